// File: doc/BRIEF.md
# Multi-Layer Road Matching Pattern Bank

This block stores a bank of track patterns. Each pattern holds one address word for each of four detector layers. While an event is in progress, hits arrive on four independent layer ports. Every pattern compares each incoming hit only with the word it stores for that hit's layer. It then keeps a sticky flag per layer, which is set once that layer has matched at least once during the event.

Each pattern feeds its four layer flags into a majority stage. The stage is a chain of four select steps, one per layer, and it produces two results. The first is a road flag, raised when the number of matched layers reaches a programmable threshold. The second is a two-bit class that tells how many layers are missing. A one-cycle event-start pulse clears all sticky flags before the next event. Pattern words are written through a separate load port that addresses one pattern and one layer at a time.

Top module: `road_match_bank`

## Requirements
- R1: After reset, every road flag is 0, every class field is 3, every stored word is 0 and the threshold is 4.
- R2: A valid hit on layer L (address bits [L*ADDR_W +: ADDR_W] of `hitAddr`) sets the layer-L flag of every pattern whose layer-L word equals it, at the first clock edge. It never sets a flag of another layer.
- R3: Once set, a layer flag stays set for the rest of the event, whatever later hits arrive.
- R4: At the clock edge after the flags change, `roadFlag[p]` is 1 exactly when pattern p's matched-layer count is at least the threshold.
- R5: The `missClass` field of pattern p (bits [2p+1:2p]) is registered together with the road flag and is coded as follows: 0 = all four layers matched, 1 = one layer missing, 2 = two layers missing, 3 = three or four layers missing.
- R6: `eventStart` clears every layer flag in one cycle. A hit presented in the same cycle is counted in the new event.
- R7: With `loadEn` high, `loadData` is written into the word of pattern `loadPat`, layer `loadLayer` (0..3). A hit in that same cycle still compares against the previous word. A load never changes any layer flag.
- R8: With `thrWrEn` high, a `thrData` value from 1 to 4 becomes the threshold. Any other value is ignored and the threshold is kept.
- R9: Hits on several layers in the same cycle are all evaluated in that cycle, each layer independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventStart | input | 1 | Clears all layer flags at the start of an event |
| hitValid | input | 4 | Hit valid, one bit per layer |
| hitAddr | input | 4*ADDR_W | Hit address words, layer L in bits [L*ADDR_W +: ADDR_W] |
| loadEn | input | 1 | Pattern word write enable |
| loadPat | input | PAT_W | Pattern index for the write |
| loadLayer | input | 2 | Layer index for the write |
| loadData | input | ADDR_W | Word to store |
| thrWrEn | input | 1 | Threshold write enable |
| thrData | input | 3 | New threshold (1..4 accepted) |
| roadFlag | output | NUM_PAT | Road found, one bit per pattern |
| missClass | output | 2*NUM_PAT | Missing-layer class, two bits per pattern |

## Verification
Two functions can act in the same cycle: a pattern load together with a hit on the layer being loaded, and an event-start pulse together with fresh hits. The bench provokes both in directed cycles and also leaves them to occur freely in the random phase. In the load case, the bench expects the hit to be compared against the old word and the new word to take effect only from the next cycle. In the event-start case, it expects the old flags to be dropped while the same-cycle hit survives. A bench-side model of flags, words and threshold predicts `roadFlag` and `missClass` at every cycle.

// File: rtl/road_bank_pkg.sv
package road_bank_pkg;
  localparam int LAYERS = 4;
  localparam int LAYER_W = 2;
  localparam int THR_W = 3;

  typedef enum logic [1:0] {
    CLS_ALL   = 2'd0,
    CLS_MISS1 = 2'd1,
    CLS_MISS2 = 2'd2,
    CLS_MISS3 = 2'd3
  } missClass_t;

  typedef struct packed {
    logic              clearEv;
    logic              loadEn;
    logic [LAYERS-1:0] layerSel;
  } bankStrobes_t;
endpackage

// File: rtl/road_bank_ctrl.sv
module road_bank_ctrl
  import road_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               eventStart,
  input  logic               loadEn,
  input  logic [LAYER_W-1:0] loadLayer,
  input  logic               thrWrEn,
  input  logic [THR_W-1:0]   thrData,
  output bankStrobes_t       strobes,
  output logic [THR_W-1:0]   thr
);
  logic thrOk;
  assign thrOk = (thrData >= THR_W'(1)) && (thrData <= THR_W'(LAYERS));

  always_ff @(posedge clk) begin
    if (!rstN) thr <= THR_W'(LAYERS);
    else if (thrWrEn && thrOk) thr <= thrData;
  end

  always_comb begin
    strobes.clearEv  = eventStart;
    strobes.loadEn   = loadEn;
    strobes.layerSel = '0;
    strobes.layerSel[loadLayer] = 1'b1;
  end
endmodule

// File: rtl/road_majority.sv
module road_majority
  import road_bank_pkg::*;
(
  input  logic [LAYERS-1:0] matchVec,
  input  logic [THR_W-1:0]  thr,
  output logic              road,
  output missClass_t        cls
);
  logic [1:0]       code [0:LAYERS];
  logic [THR_W-1:0] cnt  [0:LAYERS];

  assign code[0] = 2'd0;
  assign cnt[0]  = '0;

  for (genvar k = 0; k < LAYERS; k++) begin : g_stage
    assign code[k+1] = matchVec[k] ? code[k]
                     : ((code[k] == 2'd3) ? 2'd3 : code[k] + 2'd1);
    assign cnt[k+1]  = cnt[k] + {{(THR_W-1){1'b0}}, matchVec[k]};
  end

  assign road = (cnt[LAYERS] >= thr);
  assign cls  = missClass_t'(code[LAYERS]);
endmodule

// File: rtl/road_bank_dp.sv
module road_bank_dp
  import road_bank_pkg::*;
#(
  parameter int NUM_PAT = 16,
  parameter int ADDR_W  = 12,
  localparam int PAT_W  = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bankStrobes_t               strobes,
  input  logic [PAT_W-1:0]           loadPat,
  input  logic [ADDR_W-1:0]          loadData,
  input  logic [LAYERS-1:0]          hitValid,
  input  logic [LAYERS*ADDR_W-1:0]   hitAddr,
  input  logic [THR_W-1:0]           thr,
  output logic [NUM_PAT*LAYERS-1:0]  matchBits,
  output logic [NUM_PAT-1:0]         roadFlag,
  output logic [2*NUM_PAT-1:0]       missClass
);
  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    logic       roadNext;
    missClass_t clsNext;

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
      logic [ADDR_W-1:0] word;
      logic              hitHere;
      logic              wrHere;

      assign wrHere  = strobes.loadEn && strobes.layerSel[l] && (loadPat == PAT_W'(p));
      assign hitHere = hitValid[l] && (hitAddr[l*ADDR_W +: ADDR_W] == word);

      always_ff @(posedge clk) begin
        if (!rstN) word <= '0;
        else if (wrHere) word <= loadData;
      end

      always_ff @(posedge clk) begin
        if (!rstN) matchBits[p*LAYERS+l] <= 1'b0;
        else matchBits[p*LAYERS+l] <= (matchBits[p*LAYERS+l] & ~strobes.clearEv) | hitHere;
      end
    end

    road_majority u_maj (
      .matchVec (matchBits[p*LAYERS +: LAYERS]),
      .thr      (thr),
      .road     (roadNext),
      .cls      (clsNext)
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        roadFlag[p]        <= 1'b0;
        missClass[2*p +: 2] <= CLS_MISS3;
      end else begin
        roadFlag[p]        <= roadNext;
        missClass[2*p +: 2] <= clsNext;
      end
    end
  end
endmodule

// File: rtl/road_match_bank.sv
module road_match_bank
  import road_bank_pkg::*;
#(
  parameter int NUM_PAT = 16,
  parameter int ADDR_W  = 12,
  localparam int PAT_W  = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     eventStart,
  input  logic [LAYERS-1:0]        hitValid,
  input  logic [LAYERS*ADDR_W-1:0] hitAddr,
  input  logic                     loadEn,
  input  logic [PAT_W-1:0]         loadPat,
  input  logic [LAYER_W-1:0]       loadLayer,
  input  logic [ADDR_W-1:0]        loadData,
  input  logic                     thrWrEn,
  input  logic [THR_W-1:0]         thrData,
  output logic [NUM_PAT-1:0]       roadFlag,
  output logic [2*NUM_PAT-1:0]     missClass
);
  bankStrobes_t              strobes;
  logic [THR_W-1:0]          thr;
  logic [NUM_PAT*LAYERS-1:0] matchBits;

  road_bank_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .eventStart (eventStart),
    .loadEn     (loadEn),
    .loadLayer  (loadLayer),
    .thrWrEn    (thrWrEn),
    .thrData    (thrData),
    .strobes    (strobes),
    .thr        (thr)
  );

  road_bank_dp #(.NUM_PAT(NUM_PAT), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadPat   (loadPat),
    .loadData  (loadData),
    .hitValid  (hitValid),
    .hitAddr   (hitAddr),
    .thr       (thr),
    .matchBits (matchBits),
    .roadFlag  (roadFlag),
    .missClass (missClass)
  );
endmodule

// File: rtl/road_bank_checker.sv
module road_bank_checker
  import road_bank_pkg::*;
#(
  parameter int NUM_PAT = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      eventStart,
  input logic [LAYERS-1:0]         hitValid,
  input logic                      loadEn,
  input logic [THR_W-1:0]          thr,
  input logic [NUM_PAT*LAYERS-1:0] matchBits,
  input logic [NUM_PAT-1:0]        roadFlag,
  input logic [2*NUM_PAT-1:0]      missClass
);
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !eventStart |=> ((matchBits & $past(matchBits)) == $past(matchBits)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (eventStart && hitValid == '0) |=> (matchBits == '0));

  assert_load_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && !eventStart && hitValid == '0) |=> (matchBits == $past(matchBits)));

  assert_thr_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (thr >= THR_W'(1)) && (thr <= THR_W'(LAYERS)));

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_chk
    assert_road_R4: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (roadFlag[p] == ($countones($past(matchBits[p*LAYERS +: LAYERS])) >= int'($past(thr)))));

    assert_full_road_R5: assert property (@(posedge clk) disable iff (!rstN)
      (missClass[2*p +: 2] == 2'd0) |-> roadFlag[p]);
  end
endmodule

bind road_match_bank road_bank_checker #(.NUM_PAT(NUM_PAT)) u_chk (.*);

// File: tb/tb_road_match_bank.sv
module tb_road_match_bank;
  localparam int NP = 8;
  localparam int AW = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eventStart = 1'b0;
  logic [3:0] hitValid = '0;
  logic [4*AW-1:0] hitAddr = '0;
  logic loadEn = 1'b0;
  logic [PW-1:0] loadPat = '0;
  logic [1:0] loadLayer = '0;
  logic [AW-1:0] loadData = '0;
  logic thrWrEn = 1'b0;
  logic [2:0] thrData = '0;
  logic [NP-1:0] roadFlag;
  logic [2*NP-1:0] missClass;

  int checks = 0;
  int failures = 0;

  logic [AW-1:0] mWord [NP][4];
  bit mMatch [NP][4];
  int mThr;
  logic [NP-1:0] expRoad;
  logic [2*NP-1:0] expCls;

  always #4 clk = ~clk;

  road_match_bank #(.NUM_PAT(NP), .ADDR_W(AW)) dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] classOf(input int cnt);
    int miss = 4 - cnt;
    return (miss > 3) ? 2'd3 : 2'(miss);
  endfunction

  task automatic cycle(input string tag, input bit evS, input logic [3:0] hv,
                       input logic [4*AW-1:0] ha, input bit le, input int lp,
                       input int ll, input int ld, input bit tw, input int td);
    eventStart = evS; hitValid = hv; hitAddr = ha;
    loadEn = le; loadPat = PW'(lp); loadLayer = 2'(ll); loadData = AW'(ld);
    thrWrEn = tw; thrData = 3'(td);
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      int cnt = 0;
      for (int l = 0; l < 4; l++) cnt += mMatch[p][l];
      expRoad[p] = (cnt >= mThr);
      expCls[2*p +: 2] = classOf(cnt);
    end
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < 4; l++)
        mMatch[p][l] = (evS ? 1'b0 : mMatch[p][l]) | (hv[l] && ha[l*AW +: AW] == mWord[p][l]);
    if (le) mWord[lp][ll] = AW'(ld);
    if (tw && td >= 1 && td <= 4) mThr = td;
    @(negedge clk);
    eventStart = 0; hitValid = '0; loadEn = 0; thrWrEn = 0;
    check(tag, 32'(roadFlag), 32'(expRoad));
    check({tag, "/R5"}, 32'(missClass), 32'(expCls));
  endtask

  task automatic idle(input string tag);
    cycle(tag, 0, 4'h0, '0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [4*AW-1:0] packHits(input int a0, input int a1, input int a2, input int a3);
    return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
  endfunction

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < 4; l++) begin mWord[p][l] = '0; mMatch[p][l] = 0; end
    mThr = 4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 road", 32'(roadFlag), 0);
    check("R1 class", 32'(missClass), 32'({NP{2'b11}}));
    // R1: stored words are 0 and threshold 4: all-zero hits on 4 layers give all roads
    cycle("R1", 0, 4'hF, '0, 0, 0, 0, 0, 0, 0);
    idle("R1");
    check("R1 thr4", 32'(roadFlag), 32'({NP{1'b1}}));
    // R7: load distinct words per pattern: word = 16*p + 4*l + 1
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < 4; l++)
        cycle("R7", 0, 4'h0, '0, 1, p, l, 16*p + 4*l + 1, 0, 0);
    idle("R7");
    // R6: clear
    cycle("R6", 1, 4'h0, '0, 0, 0, 0, 0, 0, 0);
    idle("R6");
    check("R6 clear", 32'(missClass), 32'({NP{2'b11}}));
    // R2: layer-0 hit carrying pattern 2's layer-1 word matches nothing
    cycle("R2", 0, 4'h1, packHits(16*2+5, 0, 0, 0), 0, 0, 0, 0, 0, 0);
    idle("R2");
    check("R2 wrong layer", 32'(missClass), 32'({NP{2'b11}}));
    // R9: all four layers at once for pattern 3
    cycle("R9", 0, 4'hF, packHits(49, 53, 57, 61), 0, 0, 0, 0, 0, 0);
    idle("R9");
    check("R9 road p3", 32'(roadFlag[3]), 1);
    // R3: non-matching hits keep the flags
    cycle("R3", 0, 4'hF, packHits(200, 201, 202, 203), 0, 0, 0, 0, 0, 0);
    idle("R3");
    check("R3 sticky", 32'(missClass[7:6]), 0);
    // R8: illegal threshold values are ignored
    cycle("R8", 0, 4'h0, '0, 0, 0, 0, 0, 1, 0);
    cycle("R8", 0, 4'h0, '0, 0, 0, 0, 0, 1, 5);
    cycle("R8", 1, 4'h0, '0, 0, 0, 0, 0, 1, 7);
    cycle("R8", 0, 4'h7, packHits(17, 21, 25, 0), 0, 0, 0, 0, 0, 0);
    idle("R8");
    check("R8 thr kept", 32'(roadFlag[1]), 0);
    cycle("R8", 0, 4'h0, '0, 0, 0, 0, 0, 1, 2);
    idle("R8");
    check("R8 thr2", 32'(roadFlag[1]), 1);
    // R6: event start with a same-cycle hit on pattern 1 layer 3
    cycle("R6", 1, 4'h8, packHits(0, 0, 0, 29), 0, 0, 0, 0, 0, 0);
    idle("R6");
    check("R6 same-cycle hit", 32'(missClass[3:2]), 3);
    // R7: load and hit on the same word in one cycle
    cycle("R7", 0, 4'h1, packHits(17, 0, 0, 0), 1, 1, 0, 99, 0, 0);
    idle("R7");
    check("R7 old word", 32'(missClass[3:2]), 2);
    cycle("R7", 0, 4'h2, packHits(0, 21, 0, 0), 0, 0, 0, 0, 0, 0);
    idle("R7");
    check("R7 class1", 32'(missClass[3:2]), 1);
    // R4: random mix
    for (int i = 0; i < 4000; i++) begin
      bit le = ($urandom % 8) == 0;
      bit ev = ($urandom % 16) == 0;
      bit tw = ($urandom % 32) == 0;
      logic [4*AW-1:0] ha;
      for (int l = 0; l < 4; l++) ha[l*AW +: AW] = AW'($urandom % 8);
      cycle("R4", ev, 4'($urandom), ha, le, $urandom % NP, $urandom % 4,
            $urandom % 8, tw, $urandom % 8);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule